// File: doc/BRIEF.md
# Vernier Stage Hit Accumulator

This block sits behind a tapped vernier delay line used for on-chip jitter measurement. Each delay stage compares a data edge against a clock edge that is offset by a fixed step per stage. It reports 1 when the data edge arrived first. The block takes one vector of these stage results per trial. For every stage it counts how many trials reported a 1. The counts, divided by the number of trials, trace the cumulative distribution of the edge position. The difference between neighbouring stages gives the jitter histogram.

A run is armed with a trial count and a start pulse. The bank then counts only strobed trials, stops by itself after the programmed number of trials and raises a done flag. Software or a test controller then reads the per-stage totals one address at a time. A trial whose vector is not a clean thermometer code raises a sticky flag. That trial is still counted, so the raw data stays complete.

Top module: `vdl_cdf_bank`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `bubble_err_o` are low and every stage total reads as 0.
- R2: A cycle with `start_i` high (and `clear_i` low) zeroes all stage totals, the trial tally and the bubble flag, and latches `trials_i`. From the next cycle `busy_o` is high, or `done_o` is high if `trials_i` was 0. A start during a run restarts it.
- R3: While busy, each cycle with `stage_vld_i` high is one trial. Stage k's total rises by one when `stage_bits_i[k]` is 1. Bit 0 is the stage with the smallest clock offset.
- R4: Cycles with `stage_vld_i` low, or while not busy, leave every stage total unchanged.
- R5: A stage total stops at 2^CNT_W-1 and does not wrap.
- R6: The clock edge that counts the last programmed trial also drops `busy_o` and raises `done_o`. `done_o` then holds until the next start or clear. `busy_o` and `done_o` are never high together.
- R7: A counted trial with any k where `stage_bits_i[k]`=1 and `stage_bits_i[k+1]`=0 sets `bubble_err_o`. That trial is still counted. The flag stays set until a start or a clear.
- R8: A cycle with `clear_i` high zeroes all totals and drops `busy_o`, `done_o` and `bubble_err_o` in that single cycle. Clear takes priority over start.
- R9: `rd_data_o` shows the total of stage `rd_addr_i` one clock after the address is applied. An address of NUM_STAGES or more reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Arm a new run with the trial count on `trials_i` |
| clear_i | input | 1 | Zero all totals and flags, return to idle |
| trials_i | input | TRIAL_W | Number of trials for the run |
| stage_vld_i | input | 1 | One trial's stage vector is present |
| stage_bits_i | input | NUM_STAGES | Per-stage capture result, 1 = data edge first |
| rd_addr_i | input | ADDR_W | Stage to read |
| rd_data_o | output | CNT_W | Total of the addressed stage, one cycle later |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Programmed trials all counted |
| bubble_err_o | output | 1 | Sticky: a non-thermometer vector was counted |

## Verification
The hardest case to reach from the ports is a stage total at its ceiling. Reaching it takes more trials than the counter can hold, all with that stage set. The bench therefore builds the bank with narrow totals and holds the valid strobe high over a run of a few hundred all-ones vectors. This pushes every stage past its limit within one run. A restart in the middle of a run, a start that coincides with a clear, and strobes sent after completion are also driven on purpose. After each of these, every stage is read back.

// File: rtl/vdl_cdf_pkg.sv
package vdl_cdf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_state_e;
endpackage

// File: rtl/vdl_stage_counter.sv
module vdl_stage_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sat, cnt_en;

  assign sat    = (cnt_q == CNT_MAX);
  assign cnt_en = clr_i | (inc_i & ~sat);

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/vdl_trial_ctrl.sv
module vdl_trial_ctrl
  import vdl_cdf_pkg::*;
#(
  parameter int TRIAL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               clear_i,
  input  logic [TRIAL_W-1:0] trials_i,
  input  logic               vld_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               count_en_o
);
  run_state_e         state_q, state_d;
  logic [TRIAL_W-1:0] tgt_q, tgt_d;
  logic [TRIAL_W-1:0] tally_q, tally_d, tally_inc;

  assign tally_inc = tally_q + 1'b1;

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    tally_d = tally_q;
    if (clear_i) begin
      state_d = ST_IDLE;
      tally_d = '0;
    end else if (start_i) begin
      tgt_d   = trials_i;
      tally_d = '0;
      state_d = (trials_i == '0) ? ST_DONE : ST_RUN;
    end else if (state_q == ST_RUN && vld_i) begin
      tally_d = tally_inc;
      if (tally_inc == tgt_q) state_d = ST_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      tally_q <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      tally_q <= tally_d;
    end
  end

  assign busy_o     = (state_q == ST_RUN);
  assign done_o     = (state_q == ST_DONE);
  assign count_en_o = busy_o & vld_i & ~start_i & ~clear_i;
endmodule

// File: rtl/vdl_bubble_flag.sv
module vdl_bubble_flag #(
  parameter int NUM_STAGES = 101
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  sample_i,
  input  logic [NUM_STAGES-1:0] bits_i,
  output logic                  flag_o
);
  logic flag_q, flag_d, broken;

  generate
    if (NUM_STAGES > 1) begin : g_pairs
      logic [NUM_STAGES-2:0] gap;
      for (genvar k = 0; k < NUM_STAGES - 1; k++) begin : g_gap
        assign gap[k] = bits_i[k] & ~bits_i[k+1];
      end
      assign broken = |gap;
    end else begin : g_single
      assign broken = 1'b0;
    end
  endgenerate

  always_comb begin
    if (clr_i)                   flag_d = 1'b0;
    else if (sample_i && broken) flag_d = 1'b1;
    else                         flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/vdl_readout_mux.sv
module vdl_readout_mux #(
  parameter int NUM_STAGES = 101,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_STAGES*CNT_W-1:0] cnt_flat_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output logic [CNT_W-1:0]            data_o
);
  localparam logic [ADDR_W:0] STAGE_LIM = (ADDR_W + 1)'(NUM_STAGES);

  logic [CNT_W-1:0] sel_d, data_q;

  always_comb begin
    sel_d = '0;
    if ({1'b0, addr_i} < STAGE_LIM) sel_d = cnt_flat_i[int'(addr_i) * CNT_W +: CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= sel_d;
  end

  assign data_o = data_q;
endmodule

// File: rtl/vdl_cdf_bank.sv
module vdl_cdf_bank #(
  parameter int NUM_STAGES = 101,
  parameter int CNT_W      = 16,
  parameter int TRIAL_W    = 16,
  parameter int ADDR_W     = $clog2(NUM_STAGES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  clear_i,
  input  logic [TRIAL_W-1:0]    trials_i,
  input  logic                  stage_vld_i,
  input  logic [NUM_STAGES-1:0] stage_bits_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [CNT_W-1:0]      rd_data_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  bubble_err_o
);
  logic [1:0]                  rst_sync_q;
  logic                        rst_core_n;
  logic                        clr_all;
  logic                        count_en;
  logic [NUM_STAGES*CNT_W-1:0] cnt_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign clr_all = clear_i | start_i;

  vdl_trial_ctrl #(.TRIAL_W(TRIAL_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start_i    (start_i),
    .clear_i    (clear_i),
    .trials_i   (trials_i),
    .vld_i      (stage_vld_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .count_en_o (count_en)
  );

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    vdl_stage_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk   (clk),
      .rst_n (rst_core_n),
      .clr_i (clr_all),
      .inc_i (count_en & stage_bits_i[k]),
      .cnt_o (cnt_flat[k*CNT_W +: CNT_W])
    );
  end

  vdl_bubble_flag #(.NUM_STAGES(NUM_STAGES)) bubble_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr_i    (clr_all),
    .sample_i (count_en),
    .bits_i   (stage_bits_i),
    .flag_o   (bubble_err_o)
  );

  vdl_readout_mux #(
    .NUM_STAGES (NUM_STAGES),
    .CNT_W      (CNT_W),
    .ADDR_W     (ADDR_W)
  ) rdmux_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cnt_flat_i (cnt_flat),
    .addr_i     (rd_addr_i),
    .data_o     (rd_data_o)
  );
endmodule

// File: rtl/vdl_cdf_bank_chk.sv
module vdl_cdf_bank_chk #(
  parameter int NUM_STAGES = 101,
  parameter int CNT_W      = 16,
  parameter int TRIAL_W    = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        start_i,
  input logic                        clear_i,
  input logic [TRIAL_W-1:0]          trials_i,
  input logic                        stage_vld_i,
  input logic                        busy_o,
  input logic                        done_o,
  input logic                        bubble_err_o,
  input logic [NUM_STAGES*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o)); // R6

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i && !clear_i) |=> done_o); // R6

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clear_i && trials_i != '0) |=> busy_o); // R2

  AST_CLEAR_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!busy_o && !done_o && !bubble_err_o && cnt_flat == '0)); // R8

  AST_BUBBLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (bubble_err_o && !start_i && !clear_i) |=> bubble_err_o); // R7

  AST_NO_STRAY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!(busy_o && stage_vld_i) && !start_i && !clear_i) |=> $stable(cnt_flat)); // R4

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_sat
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_flat[k*CNT_W +: CNT_W] == CNT_MAX && !start_i && !clear_i)
        |=> cnt_flat[k*CNT_W +: CNT_W] == CNT_MAX); // R5
  end
endmodule

bind vdl_cdf_bank vdl_cdf_bank_chk #(
  .NUM_STAGES (NUM_STAGES),
  .CNT_W      (CNT_W),
  .TRIAL_W    (TRIAL_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .start_i      (start_i),
  .clear_i      (clear_i),
  .trials_i     (trials_i),
  .stage_vld_i  (stage_vld_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .bubble_err_o (bubble_err_o),
  .cnt_flat     (cnt_flat)
);

// File: tb/vdl_cdf_bank_tb_top.sv
module vdl_cdf_bank_tb_top;
  localparam int NS  = 12;
  localparam int CW  = 8;
  localparam int TW  = 16;
  localparam int AW  = 4;
  localparam int MAXC = (1 << CW) - 1;

  typedef struct {
    int    stage;
    int    exp;
    string tag;
  } rd_item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          clear_i = 1'b0;
  logic [TW-1:0] trials_i = '0;
  logic          stage_vld_i = 1'b0;
  logic [NS-1:0] stage_bits_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [CW-1:0] rd_data_o;
  logic          busy_o, done_o, bubble_err_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  rd_item_t exp_q[$];

  int  m_cnt [NS];
  bit  m_busy, m_done, m_bub;
  int  m_tally, m_target;

  always #10 clk = ~clk;

  vdl_cdf_bank #(.NUM_STAGES(NS), .CNT_W(CW), .TRIAL_W(TW), .ADDR_W(AW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .clear_i      (clear_i),
    .trials_i     (trials_i),
    .stage_vld_i  (stage_vld_i),
    .stage_bits_i (stage_bits_i),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .bubble_err_o (bubble_err_o)
  );

  task automatic check_eq(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] therm(int m);
    logic [NS-1:0] v;
    for (int k = 0; k < NS; k++) v[k] = (k >= m);
    return v;
  endfunction

  function automatic bit has_gap(logic [NS-1:0] v);
    for (int k = 0; k < NS - 1; k++) if (v[k] && !v[k+1]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_zero();
    for (int k = 0; k < NS; k++) m_cnt[k] = 0;
    m_bub = 1'b0;
    m_tally = 0;
  endtask

  task automatic do_start(int t);
    @(negedge clk);
    start_i = 1'b1;
    trials_i = TW'(t);
    model_zero();
    m_target = t;
    m_busy = (t != 0);
    m_done = (t == 0);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(logic [NS-1:0] v);
    @(negedge clk);
    stage_vld_i = 1'b1;
    stage_bits_i = v;
    if (m_busy) begin
      for (int k = 0; k < NS; k++) if (v[k] && m_cnt[k] < MAXC) m_cnt[k]++;
      if (has_gap(v)) m_bub = 1'b1;
      m_tally++;
      if (m_tally == m_target) begin
        m_busy = 1'b0;
        m_done = 1'b1;
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      stage_vld_i = 1'b0;
      stage_bits_i = '0;
    end
  endtask

  task automatic check_status(string tag);
    check_eq({tag, " busy"}, int'(busy_o), int'(m_busy));
    check_eq({tag, " done"}, int'(done_o), int'(m_done));
    check_eq({tag, " bubble"}, int'(bubble_err_o), int'(m_bub));
  endtask

  task automatic read_stage(int a, int exp, string tag);
    rd_item_t it;
    @(negedge clk);
    rd_addr_i = AW'(a);
    it.stage = a;
    it.exp = exp;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic read_all(string tag);
    for (int k = 0; k < NS; k++) read_stage(k, m_cnt[k], tag);
    idle(2);
  endtask

  initial begin : monitor
    rd_item_t cur;
    forever begin
      @(posedge clk);
      if (exp_q.size() > 0) begin
        cur = exp_q.pop_front();
        @(negedge clk);
        check_eq($sformatf("%s stage%0d", cur.tag, cur.stage), int'(rd_data_o), cur.exp);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : driver
    m_busy = 1'b0;
    m_done = 1'b0;
    m_target = 0;
    model_zero();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_status("R1 reset");
    read_all("R1 reset");

    // R2 start arms, R3 counting with mixed patterns and gaps, R6 completion
    do_start(5);
    check_status("R2 armed");
    send(therm(3));
    send(therm(0));
    idle(2);
    send(therm(NS));
    idle(1);
    send(therm(6));
    idle(1);
    check_status("R6 still running");
    send(therm(11));
    idle(1);
    check_status("R6 completion");
    read_all("R3 totals");

    // R4 strobes after completion are ignored
    send(therm(0));
    send(therm(2));
    idle(1);
    check_status("R4 after done");
    read_all("R4 idle strobes");

    // R9 out-of-range addresses read as 0
    read_stage(NS, 0, "R9 addr NS");
    read_stage(15, 0, "R9 addr 15");
    idle(2);

    // R7 bubble flag: set, sticky, trial still counted
    do_start(3);
    read_stage(NS - 1, 0, "R2 cleared on start");
    idle(2);
    send(12'b0000_0000_0101);
    idle(1);
    check_status("R7 bubble set");
    send(therm(4));
    idle(1);
    check_status("R7 bubble sticky");
    send(therm(2));
    idle(1);
    check_status("R7 run end");
    read_all("R7 counted");

    // R8 clear together with start: clear wins
    @(negedge clk);
    clear_i = 1'b1;
    start_i = 1'b1;
    trials_i = TW'(4);
    model_zero();
    m_busy = 1'b0;
    m_done = 1'b0;
    @(negedge clk);
    clear_i = 1'b0;
    start_i = 1'b0;
    check_status("R8 clear");
    send(therm(0));
    idle(1);
    read_all("R8 cleared");

    // R2 zero trials completes at once
    do_start(0);
    check_status("R2 zero trials");

    // R5 saturation with held valid
    do_start(300);
    for (int i = 0; i < 300; i++) send(therm(0));
    idle(1);
    check_status("R5 long run");
    read_all("R5 saturate");

    // R2 restart in the middle of a run
    do_start(10);
    send(therm(1));
    send(therm(5));
    idle(1);
    do_start(2);
    send(therm(7));
    idle(1);
    check_status("R2 restart running");
    send(therm(9));
    idle(1);
    check_status("R2 restart done");
    read_all("R2 restart totals");

    idle(3);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule